// File: doc/BRIEF.md
# UART Channel Sleep Controller

This block decides when one UART channel may stop its UART clock and its baud-rate clock, and when those clocks must start again. It runs on the reference clock, which never stops. Each cycle it checks a set of idle conditions: the receive line is at its idle (high) level, the transmit FIFO, the transmit shift register and the receive FIFO are all empty, and no blocking interrupt is pending. Sleep is allowed only when two software enable bits are both set. The idle condition must hold on two consecutive reference cycles before the channel goes to sleep. This filters out one-cycle gaps in the idle state.

When the channel enters sleep, the block stores the receive-line level and the modem input levels. While asleep, it compares the live levels with these stored copies. Any difference wakes the channel, and so does a write strobe into the transmit FIFO or the clearing of either enable bit. The clock-gate enable goes to an external gating cell. A write to the divisor latches while the channel is asleep is not allowed. Such a write sets an error flag that stays set until reset.

Top module: `uart_sleep_ctl`

## Requirements
- R1: Sleep is entered only while both `enhEn` and `sleepEn` are 1. If either enable is 0 at a rising edge while the channel is asleep, `asleep` is 0 after that edge.
- R2: Sleep is not entered while `rxLine` is 0. The idle level of the receive line is 1.
- R3: Sleep is not entered unless both `txFifoEmpty` and `txShiftEmpty` are 1.
- R4: In `intPending`, bit 0 is transmit-holding-empty and bit 1 is receive time-out. These two bits do not block sleep. Any other set bit blocks sleep.
- R5: Sleep is not entered while `rxFifoEmpty` is 0.
- R6: From the awake state, `asleep` becomes 1 at the second of two consecutive rising edges at which the enables and all idle conditions hold. A condition that is broken every other cycle never causes sleep.
- R7: After reset, `asleep` is 0, `clkGateEn` is 1 and `divWrErr` is 0. `clkGateEn` is 0 exactly while `asleep` is 1.
- R8: While asleep, a change of `rxLine` from the level it had at sleep entry wakes the channel at the next rising edge. A steady line keeps the channel asleep.
- R9: While asleep, a change of any `modemIn` bit from the value stored at entry wakes the channel at the next rising edge. Nonzero levels that stay unchanged do not wake it.
- R10: A `txWrite` strobe while asleep wakes the channel at the next rising edge. A `txWrite` strobe also counts as not idle for sleep entry.
- R11: A `divWrite` strobe sampled while asleep sets `divWrErr`, which stays 1 until reset. A `divWrite` while awake leaves `divWrErr` at 0.
- R12: After a wake, entering sleep again needs two fresh consecutive idle edges, counted after the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enhEn | input | 1 | Enhanced-functions enable bit |
| sleepEn | input | 1 | Sleep enable bit |
| rxLine | input | 1 | Serial receive line, idle high |
| modemIn | input | MODEM_W | Modem status input pins |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rxFifoEmpty | input | 1 | Receive FIFO is empty |
| intPending | input | INT_W | Pending interrupt sources, bit 0 TX-holding-empty, bit 1 RX time-out |
| txWrite | input | 1 | Write strobe into the transmit FIFO |
| divWrite | input | 1 | Write strobe to a divisor latch |
| clkGateEn | output | 1 | 1 lets the UART and baud clocks run |
| asleep | output | 1 | Channel is in sleep |
| divWrErr | output | 1 | Sticky flag for a divisor write while asleep |

## Verification
Each idle condition is broken on its own while the others hold. A missing term in the entry condition then shows up as an unwanted sleep. The two ignored interrupt bits are set together to show that the interrupt mask is neither too wide nor too narrow. A condition that alternates every cycle, and an exact edge count after the enables are set, separate the two-cycle qualifier from a one-cycle one. Wake tests enter sleep with nonzero modem levels and then change one bit. This shows that the compare is made against the stored levels and not against fixed idle values. The tests also use a transmit write followed by idle inputs to check that re-entry needs a fresh count.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // store line levels this edge (sleep entry)
    logic armed;    // channel is asleep, compare is live
  } sleepStrobe_t;
endpackage

// File: rtl/sleep_datapath.sv
module sleep_datapath
  import sleep_ctl_pkg::*;
#(
  parameter int MODEM_W = 4,
  parameter int INT_W = 6,
  parameter logic [INT_W-1:0] IGN_MASK = 6'b000011
) (
  input  logic               clk,
  input  logic               rstN,
  input  sleepStrobe_t       strobe,
  input  logic               rxLine,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               txFifoEmpty,
  input  logic               txShiftEmpty,
  input  logic               rxFifoEmpty,
  input  logic [INT_W-1:0]   intPending,
  input  logic               txWrite,
  output logic               idleNow,
  output logic               changeSeen
);
  localparam logic [INT_W-1:0] BLOCK_MASK = ~IGN_MASK;

  logic               rxSnap;
  logic [MODEM_W-1:0] modemSnap;
  logic [MODEM_W-1:0] modemDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSnap    <= 1'b1;
      modemSnap <= '0;
    end else if (strobe.capture) begin
      rxSnap    <= rxLine;
      modemSnap <= modemIn;
    end
  end

  for (genvar i = 0; i < MODEM_W; i++) begin : g_modemCmp
    assign modemDiff[i] = modemIn[i] ^ modemSnap[i];
  end

  always_comb begin
    idleNow = rxLine && txFifoEmpty && txShiftEmpty && rxFifoEmpty &&
              ((intPending & BLOCK_MASK) == '0) && !txWrite;
    changeSeen = strobe.armed && ((rxLine != rxSnap) || (|modemDiff));
  end
endmodule

// File: rtl/sleep_control.sv
module sleep_control
  import sleep_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enhEn,
  input  logic         sleepEn,
  input  logic         idleNow,
  input  logic         changeSeen,
  input  logic         txWrite,
  input  logic         divWrite,
  output sleepStrobe_t strobe,
  output logic         asleep,
  output logic         divWrErr
);
  logic allowed;
  logic idleQ;
  logic enterNow;
  logic wakeNow;

  always_comb begin
    allowed  = enhEn && sleepEn;
    enterNow = !asleep && allowed && idleNow && idleQ;
    wakeNow  = asleep && (!allowed || changeSeen || txWrite);
    strobe.capture = enterNow;
    strobe.armed   = asleep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleQ    <= 1'b0;
      asleep   <= 1'b0;
      divWrErr <= 1'b0;
    end else begin
      idleQ <= !asleep && allowed && idleNow;
      if (enterNow)     asleep <= 1'b1;
      else if (wakeNow) asleep <= 1'b0;
      if (asleep && divWrite) divWrErr <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int MODEM_W = 4,
  parameter int INT_W = 6,
  parameter logic [INT_W-1:0] IGN_MASK = 6'b000011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enhEn,
  input  logic               sleepEn,
  input  logic               rxLine,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               txFifoEmpty,
  input  logic               txShiftEmpty,
  input  logic               rxFifoEmpty,
  input  logic [INT_W-1:0]   intPending,
  input  logic               txWrite,
  input  logic               divWrite,
  output logic               clkGateEn,
  output logic               asleep,
  output logic               divWrErr
);
  sleepStrobe_t strobe;
  logic idleNow;
  logic changeSeen;

  sleep_datapath #(.MODEM_W(MODEM_W), .INT_W(INT_W), .IGN_MASK(IGN_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLine(rxLine), .modemIn(modemIn),
    .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty), .rxFifoEmpty(rxFifoEmpty),
    .intPending(intPending), .txWrite(txWrite), .idleNow(idleNow), .changeSeen(changeSeen)
  );

  sleep_control ctl_i (
    .clk(clk), .rstN(rstN), .enhEn(enhEn), .sleepEn(sleepEn), .idleNow(idleNow),
    .changeSeen(changeSeen), .txWrite(txWrite), .divWrite(divWrite),
    .strobe(strobe), .asleep(asleep), .divWrErr(divWrErr)
  );

  assign clkGateEn = !asleep;
endmodule

// File: rtl/uart_sleep_ctl_chk.sv
module uart_sleep_ctl_chk #(
  parameter int MODEM_W = 4,
  parameter int INT_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               enhEn,
  input logic               sleepEn,
  input logic               rxLine,
  input logic [MODEM_W-1:0] modemIn,
  input logic               txFifoEmpty,
  input logic               txShiftEmpty,
  input logic               rxFifoEmpty,
  input logic               txWrite,
  input logic               divWrite,
  input logic               asleep,
  input logic               divWrErr
);
  p_entry_enables_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(enhEn && sleepEn));
  p_disable_wakes_r1: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !(enhEn && sleepEn)) |=> !asleep);
  p_entry_rx_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(rxLine));
  p_entry_tx_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(txFifoEmpty && txShiftEmpty));
  p_entry_rx_fifo_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(rxFifoEmpty));
  p_rx_change_wakes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && $past(asleep) && (rxLine != $past(rxLine))) |=> !asleep);
  p_modem_change_wakes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && $past(asleep) && (modemIn != $past(modemIn))) |=> !asleep);
  p_tx_write_wakes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && txWrite) |=> !asleep);
  p_div_err_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && divWrite) |=> divWrErr);
  p_div_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    divWrErr |=> divWrErr);
endmodule

bind uart_sleep_ctl uart_sleep_ctl_chk #(.MODEM_W(MODEM_W), .INT_W(INT_W)) chk_i (
  .clk(clk), .rstN(rstN), .enhEn(enhEn), .sleepEn(sleepEn), .rxLine(rxLine),
  .modemIn(modemIn), .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
  .rxFifoEmpty(rxFifoEmpty), .txWrite(txWrite), .divWrite(divWrite),
  .asleep(asleep), .divWrErr(divWrErr)
);

// File: tb/uart_sleep_ctl_tb_top.sv
module uart_sleep_ctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enhEn = 1'b0, sleepEn = 1'b0, rxLine = 1'b1;
  logic [3:0] modemIn = '0;
  logic txFifoEmpty = 1'b1, txShiftEmpty = 1'b1, rxFifoEmpty = 1'b1;
  logic [5:0] intPending = '0;
  logic txWrite = 1'b0, divWrite = 1'b0;
  logic clkGateEn, asleep, divWrErr;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  uart_sleep_ctl dut_i (
    .clk(clk), .rstN(rstN), .enhEn(enhEn), .sleepEn(sleepEn), .rxLine(rxLine),
    .modemIn(modemIn), .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
    .rxFifoEmpty(rxFifoEmpty), .intPending(intPending), .txWrite(txWrite),
    .divWrite(divWrite), .clkGateEn(clkGateEn), .asleep(asleep), .divWrErr(divWrErr)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge; inputs change and outputs are read at the falling edge.
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setIdle();
    rxLine = 1'b1; txFifoEmpty = 1'b1; txShiftEmpty = 1'b1; rxFifoEmpty = 1'b1;
    intPending = '0; txWrite = 1'b0; divWrite = 1'b0;
  endtask

  task automatic forceWake();
    enhEn = 1'b0; step(1);
    check("R1 wake on enable clear", asleep, 1'b0);
  endtask

  task automatic goSleep(input string tag);
    setIdle(); enhEn = 1'b1; sleepEn = 1'b1;
    step(1);
    check({tag, " R6 one edge not yet asleep"}, asleep, 1'b0);
    step(1);
    check({tag, " R6 asleep at second edge"}, asleep, 1'b1);
    check({tag, " R7 gate off while asleep"}, clkGateEn, 1'b0);
  endtask

  task automatic tReset();
    check("R7 reset asleep", asleep, 1'b0);
    check("R7 reset gate", clkGateEn, 1'b1);
    check("R7 reset err", divWrErr, 1'b0);
  endtask

  task automatic tEnables();
    setIdle(); enhEn = 1'b1; sleepEn = 1'b0; step(4);
    check("R1 only enhanced enable", asleep, 1'b0);
    enhEn = 1'b0; sleepEn = 1'b1; step(4);
    check("R1 only sleep enable", asleep, 1'b0);
    goSleep("enables");
    sleepEn = 1'b0; step(1);
    check("R1 sleep enable clear wakes", asleep, 1'b0);
    check("R7 gate back on", clkGateEn, 1'b1);
  endtask

  task automatic tryBlocked(input string tag, input int which);
    enhEn = 1'b0; step(1);
    setIdle();
    case (which)
      0: rxLine = 1'b0;
      1: txFifoEmpty = 1'b0;
      2: txShiftEmpty = 1'b0;
      3: rxFifoEmpty = 1'b0;
      4: intPending = 6'b000100;
      5: intPending = 6'b100000;
      default: txWrite = 1'b1;
    endcase
    enhEn = 1'b1; sleepEn = 1'b1; step(4);
    check(tag, asleep, 1'b0);
    setIdle(); enhEn = 1'b0; step(1);
  endtask

  task automatic tBlockers();
    tryBlocked("R2 rx low blocks", 0);
    tryBlocked("R3 tx fifo blocks", 1);
    tryBlocked("R3 tx shift blocks", 2);
    tryBlocked("R5 rx fifo blocks", 3);
    tryBlocked("R4 int bit2 blocks", 4);
    tryBlocked("R4 int bit5 blocks", 5);
    tryBlocked("R10 tx write blocks entry", 6);
    setIdle(); intPending = 6'b000011; enhEn = 1'b1; sleepEn = 1'b1; step(2);
    check("R4 ignored ints allow sleep", asleep, 1'b1);
    forceWake();
    setIdle();
  endtask

  task automatic tGlitch();
    setIdle(); enhEn = 1'b1; sleepEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rxFifoEmpty = (i % 2 == 0);
      step(1);
      check("R6 alternating idle never sleeps", asleep, 1'b0);
    end
    setIdle(); enhEn = 1'b0; step(1);
  endtask

  task automatic tRxWake();
    goSleep("rx");
    step(3);
    check("R8 steady rx stays asleep", asleep, 1'b1);
    rxLine = 1'b0; step(1);
    check("R8 rx edge wakes", asleep, 1'b0);
    forceWake(); setIdle();
  endtask

  task automatic tModemWake();
    modemIn = 4'b0101;
    goSleep("modem");
    step(3);
    check("R9 steady nonzero modem stays asleep", asleep, 1'b1);
    modemIn = 4'b0111; step(1);
    check("R9 modem change wakes", asleep, 1'b0);
    forceWake(); setIdle();
  endtask

  task automatic tTxWake();
    goSleep("tx");
    txWrite = 1'b1; step(1);
    check("R10 tx write wakes", asleep, 1'b0);
    txWrite = 1'b0; step(1);
    check("R12 first idle edge after wake", asleep, 1'b0);
    step(1);
    check("R12 re-entry at second fresh edge", asleep, 1'b1);
    forceWake(); setIdle();
  endtask

  task automatic tDivErr();
    enhEn = 1'b0; divWrite = 1'b1; step(1); divWrite = 1'b0; step(1);
    check("R11 awake divisor write ignored", divWrErr, 1'b0);
    goSleep("div");
    divWrite = 1'b1; step(1); divWrite = 1'b0;
    check("R11 asleep divisor write flags", divWrErr, 1'b1);
    forceWake(); step(3);
    check("R11 error sticky", divWrErr, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    tReset();
    tEnables();
    tBlockers();
    tGlitch();
    tRxWake();
    tModemWake();
    tTxWake();
    tDivErr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule